// File: doc/BRIEF.md
# CAN Fault-Confinement State Classifier

This block sorts a CAN controller's error picture into one of four fault-confinement states. Its inputs are an error-flag byte, an error-warning status bit and the transmit and receive error counters. On each sample strobe it works out the state these inputs imply and compares it with the state it holds. When the two differ it emits a one-cycle change event. The event carries the new state and copies of both counters. It also says whether the change is charged to the transmit side, the receive side or both.

In the same sample the block can report a single protocol-error cause. It does so when a bus-error interrupt is pending, error reporting is enabled and at least one protocol-error flag is set. If bus-off is entered while automatic restart is off, the block pulses a sleep request and latches a quit flag. It then stays silent until a restart input arrives. The counters themselves and the protocol engine are kept outside the block.

Top module: `can_fault_state`

## Requirements
- R1: Flag byte layout: bit 7 bus-off, bit 6 transmit passive, bit 5 receive passive, bit 4 bit error, bit 3 form error, bit 2 CRC error, bit 1 ack error, bit 0 stuff error. The computed state is bus-off (code 3) when bit 7 is set. Failing that it is error-passive (code 2), then error-warning (code 1) when warn_i is high, and otherwise error-active (code 0).
- R2: Either passive bit alone (6 or 5) is enough to select error-passive when bus-off is clear.
- R3: A sample with sample_i high produces a change event only when the computed state differs from the stored one. The event is a one-cycle pulse of chg_evt_o. On that same edge state_o takes the new state, and chg_state_o, evt_tec_o and evt_rec_o carry the new state, TEC and REC. Outside an event these payload outputs are zero.
- R4: On a change event, tx_side_o is high exactly when TEC >= REC and rx_side_o is high exactly when TEC <= REC, so equal counters set both.
- R5: The protocol-error cause reported on perr_cause_o is the first set flag in the order bit (code 1), form (2), stuff (3), CRC (4), ack (5). It is 0 when no event is reported.
- R6: perr_evt_o pulses for one cycle only when bus_err_irq_i, berr_report_en_i and at least one of flag bits 4 to 0 are all high in a sample.
- R7: Entering bus-off with auto_restart_en_i low pulses sleep_req_o, sets quit_o and suppresses the protocol-error event of that sample. While quit_o is high, samples produce no events and leave the state unchanged.
- R8: restart_i forces the stored state to error-active and clears quit_o, producing no event. It takes priority over a sample in the same cycle.
- R9: Entering bus-off with auto_restart_en_i high neither sets quit_o nor pulses sleep_req_o, and protocol-error reporting continues.
- R10: When sample_i is low, flag and counter inputs have no effect: no events, and the state is held.
- R11: After reset the state is error-active, quit_o is low and all event outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Evaluate inputs this cycle |
| err_flags_i | input | 8 | Error-flag byte |
| warn_i | input | 1 | Error-warning status bit |
| tec_i | input | CNT_W | Transmit error counter |
| rec_i | input | CNT_W | Receive error counter |
| bus_err_irq_i | input | 1 | Bus-error interrupt pending |
| berr_report_en_i | input | 1 | Protocol-error reporting enable |
| auto_restart_en_i | input | 1 | Automatic restart after bus-off enabled |
| restart_i | input | 1 | Restart request |
| state_o | output | 2 | Stored fault-confinement state |
| chg_evt_o | output | 1 | State-change event pulse |
| chg_state_o | output | 2 | New state carried by the event |
| tx_side_o | output | 1 | Change charged to transmit side |
| rx_side_o | output | 1 | Change charged to receive side |
| evt_tec_o | output | CNT_W | TEC copy carried by the event |
| evt_rec_o | output | CNT_W | REC copy carried by the event |
| perr_evt_o | output | 1 | Protocol-error event pulse |
| perr_cause_o | output | 3 | Protocol-error cause code |
| sleep_req_o | output | 1 | Sleep request pulse |
| quit_o | output | 1 | Event generation halted until restart |

## Verification
The stimulus walks the state through every transition, including warning-only, passive from each side alone and bus-off with all lower bits also set. Together these show that the priority is honoured rather than the lowest set bit. The counters are set to TEC greater than REC, REC greater than TEC and exactly equal, which separates a strict comparison from an inclusive one. Flag words with several protocol bits set at once are driven so that only the intended winner matches; for example stuff and CRC are set together, which catches a cause chain ordered by bit position. Each gating input of the protocol-error event is dropped in turn, and bus-off is entered once with automatic restart on and once with it off. The run also covers samples taken while quit is set, a strobe-low cycle carrying bus-off flags, and restart followed by a fresh change.

// File: rtl/errstate_pkg.sv
package errstate_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_WARN    = 2'd1,
    ST_PASSIVE = 2'd2,
    ST_BUSOFF  = 2'd3
  } fc_state_e;

  typedef enum logic [2:0] {
    CZ_NONE  = 3'd0,
    CZ_BIT   = 3'd1,
    CZ_FORM  = 3'd2,
    CZ_STUFF = 3'd3,
    CZ_CRC   = 3'd4,
    CZ_ACK   = 3'd5
  } perr_cause_e;

  localparam int FLAG_W    = 8;
  localparam int FB_BUSOFF = 7;
  localparam int FB_TXP    = 6;
  localparam int FB_RXP    = 5;
  localparam int FB_BIT    = 4;
  localparam int FB_FORM   = 3;
  localparam int FB_CRC    = 2;
  localparam int FB_ACK    = 1;
  localparam int FB_STUFF  = 0;
  localparam int PROTO_N   = 5;

  // flag bit picked at each priority rank; rank k reports cause code k+1
  localparam int PRIO_BIT [PROTO_N] = '{FB_BIT, FB_FORM, FB_STUFF, FB_CRC, FB_ACK};
endpackage

// File: rtl/es_classify.sv
module es_classify
  import errstate_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              warn_i,
  output fc_state_e         state_o
);
  always_comb begin
    if (flags_i[FB_BUSOFF])                        state_o = ST_BUSOFF;
    else if (flags_i[FB_TXP] || flags_i[FB_RXP])   state_o = ST_PASSIVE;
    else if (warn_i)                               state_o = ST_WARN;
    else                                           state_o = ST_ACTIVE;
  end
endmodule

// File: rtl/es_cause_pick.sv
module es_cause_pick
  import errstate_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  output perr_cause_e       cause_o,
  output logic              any_o
);
  always_comb begin
    cause_o = CZ_NONE;
    // walk from lowest rank up so the highest-ranked set flag wins
    for (int k = PROTO_N - 1; k >= 0; k--) begin
      if (flags_i[PRIO_BIT[k]]) cause_o = perr_cause_e'(3'(k + 1));
    end
    any_o = (cause_o != CZ_NONE);
  end
endmodule

// File: rtl/es_attrib.sv
module es_attrib #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] tec_i,
  input  logic [CNT_W-1:0] rec_i,
  output logic             tx_side_o,
  output logic             rx_side_o
);
  assign tx_side_o = (tec_i >= rec_i);
  assign rx_side_o = (tec_i <= rec_i);
endmodule

// File: rtl/can_fault_state.sv
module can_fault_state
  import errstate_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic [7:0]       err_flags_i,
  input  logic             warn_i,
  input  logic [CNT_W-1:0] tec_i,
  input  logic [CNT_W-1:0] rec_i,
  input  logic             bus_err_irq_i,
  input  logic             berr_report_en_i,
  input  logic             auto_restart_en_i,
  input  logic             restart_i,
  output logic [1:0]       state_o,
  output logic             chg_evt_o,
  output logic [1:0]       chg_state_o,
  output logic             tx_side_o,
  output logic             rx_side_o,
  output logic [CNT_W-1:0] evt_tec_o,
  output logic [CNT_W-1:0] evt_rec_o,
  output logic             perr_evt_o,
  output logic [2:0]       perr_cause_o,
  output logic             sleep_req_o,
  output logic             quit_o
);
  fc_state_e   new_st, state_q, chg_st_q;
  perr_cause_e cause_c, cause_q;
  logic        any_proto, tx_c, rx_c;
  logic        chg_q, tx_q, rx_q, perr_q, sleep_q, quit_q;
  logic [CNT_W-1:0] tec_q, rec_q;
  logic        differs, stop_now, perr_fire, live;

  es_classify u_cls (
    .flags_i (err_flags_i),
    .warn_i  (warn_i),
    .state_o (new_st)
  );

  es_cause_pick u_cause (
    .flags_i (err_flags_i),
    .cause_o (cause_c),
    .any_o   (any_proto)
  );

  es_attrib #(.CNT_W(CNT_W)) u_att (
    .tec_i     (tec_i),
    .rec_i     (rec_i),
    .tx_side_o (tx_c),
    .rx_side_o (rx_c)
  );

  assign live      = sample_i && !quit_q && !restart_i;
  assign differs   = (new_st != state_q);
  assign stop_now  = differs && (new_st == ST_BUSOFF) && !auto_restart_en_i;
  assign perr_fire = bus_err_irq_i && berr_report_en_i && any_proto && !stop_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_ACTIVE;
      quit_q   <= 1'b0;
      chg_q    <= 1'b0;
      chg_st_q <= ST_ACTIVE;
      tx_q     <= 1'b0;
      rx_q     <= 1'b0;
      tec_q    <= '0;
      rec_q    <= '0;
      perr_q   <= 1'b0;
      cause_q  <= CZ_NONE;
      sleep_q  <= 1'b0;
    end else begin
      chg_q    <= 1'b0;
      chg_st_q <= ST_ACTIVE;
      tx_q     <= 1'b0;
      rx_q     <= 1'b0;
      tec_q    <= '0;
      rec_q    <= '0;
      perr_q   <= 1'b0;
      cause_q  <= CZ_NONE;
      sleep_q  <= 1'b0;
      if (restart_i) begin
        state_q <= ST_ACTIVE;
        quit_q  <= 1'b0;
      end else if (live) begin
        if (differs) begin
          state_q  <= new_st;
          chg_q    <= 1'b1;
          chg_st_q <= new_st;
          tx_q     <= tx_c;
          rx_q     <= rx_c;
          tec_q    <= tec_i;
          rec_q    <= rec_i;
        end
        if (stop_now) begin
          quit_q  <= 1'b1;
          sleep_q <= 1'b1;
        end
        if (perr_fire) begin
          perr_q  <= 1'b1;
          cause_q <= cause_c;
        end
      end
    end
  end

  assign state_o      = state_q;
  assign chg_evt_o    = chg_q;
  assign chg_state_o  = chg_st_q;
  assign tx_side_o    = tx_q;
  assign rx_side_o    = rx_q;
  assign evt_tec_o    = tec_q;
  assign evt_rec_o    = rec_q;
  assign perr_evt_o   = perr_q;
  assign perr_cause_o = cause_q;
  assign sleep_req_o  = sleep_q;
  assign quit_o       = quit_q;

  AST_EVT_CARRIES_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_evt_o |-> (chg_state_o == state_o)) else $error("event state mismatch"); // R3
  AST_EVT_IS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_evt_o |-> (state_o != $past(state_o))) else $error("event without change"); // R3
  AST_SIDE_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_evt_o |-> (tx_side_o || rx_side_o)) else $error("event blamed on no side"); // R4
  AST_CAUSE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_evt_o |-> (perr_cause_o >= 3'd1 && perr_cause_o <= 3'd5)) else $error("bad cause"); // R5
  AST_SLEEP_AT_BUSOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_req_o |-> (state_o == 2'd3 && quit_o && !perr_evt_o)) else $error("sleep outside bus-off"); // R7
  AST_QUIT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(quit_o) |-> (!chg_evt_o && !perr_evt_o && !sleep_req_o)) else $error("event while quit"); // R7
  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(restart_i) |-> (state_o == 2'd0 && !quit_o && !chg_evt_o)) else $error("restart ignored"); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(sample_i) && !$past(restart_i)) |-> ($stable(state_o) && !chg_evt_o && !perr_evt_o))
    else $error("state moved without sample"); // R10
endmodule

// File: tb/sim_can_fault_state.sv
`timescale 1ns/1ps
module sim_can_fault_state;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       sample = 0, warn = 0, irq = 0, rep = 0, ar = 0, rs = 0;
  logic [7:0] flags = 0, tec = 0, rec = 0;
  logic [1:0] st, cst;
  logic       chg, txs, rxs, pe, sl, qt;
  logic [7:0] et, er;
  logic [2:0] pc;

  can_fault_state u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .err_flags_i(flags), .warn_i(warn),
    .tec_i(tec), .rec_i(rec), .bus_err_irq_i(irq), .berr_report_en_i(rep),
    .auto_restart_en_i(ar), .restart_i(rs), .state_o(st), .chg_evt_o(chg),
    .chg_state_o(cst), .tx_side_o(txs), .rx_side_o(rxs), .evt_tec_o(et), .evt_rec_o(er),
    .perr_evt_o(pe), .perr_cause_o(pc), .sleep_req_o(sl), .quit_o(qt)
  );

  int n_run = 0, n_fail = 0;
  logic [28:0] exp_q [$];
  string       tag_q [$];
  logic [1:0]  m_st = 0;
  logic        m_quit = 0;
  bit          done = 0;

  function automatic logic [28:0] pack_act();
    return {st, chg, cst, txs, rxs, et, er, pe, pc, sl, qt};
  endfunction

  task automatic drive(input logic s, input logic [7:0] f, input logic w,
                       input logic [7:0] t, input logic [7:0] r, input logic i,
                       input logic p, input logic a, input logic restart, input string tag);
    logic [1:0] ns, e_cst;
    logic e_chg, e_tx, e_rx, e_pe, e_sl, stop, fire;
    logic [7:0] e_et, e_er;
    logic [2:0] e_pc;
    @(negedge clk);
    sample = s; flags = f; warn = w; tec = t; rec = r; irq = i; rep = p; ar = a; rs = restart;
    e_chg = 0; e_cst = 0; e_tx = 0; e_rx = 0; e_et = 0; e_er = 0; e_pe = 0; e_pc = 0; e_sl = 0;
    if (restart) begin
      m_st = 0; m_quit = 0;
    end else if (s && !m_quit) begin
      if (f[7]) ns = 3;
      else if (f[6] | f[5]) ns = 2;
      else if (w) ns = 1;
      else ns = 0;
      stop = (ns == 3) && (ns != m_st) && !a;
      fire = i && p && (f[4:0] != 0) && !stop;
      if (ns != m_st) begin
        e_chg = 1; e_cst = ns; e_tx = (t >= r); e_rx = (t <= r); e_et = t; e_er = r;
        m_st = ns;
      end
      if (stop) begin m_quit = 1; e_sl = 1; end
      if (fire) begin
        e_pe = 1;
        if (f[4]) e_pc = 1;
        else if (f[3]) e_pc = 2;
        else if (f[0]) e_pc = 3;
        else if (f[2]) e_pc = 4;
        else e_pc = 5;
      end
    end
    exp_q.push_back({m_st, e_chg, e_cst, e_tx, e_rx, e_et, e_er, e_pe, e_pc, e_sl, m_quit});
    tag_q.push_back(tag);
  endtask

  // monitor: compares each result just after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [28:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        n_run++;
        if (pack_act() !== e) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", tg, pack_act(), e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    @(negedge clk);
    n_run++;
    if (pack_act() !== 29'd0) begin
      n_fail++;
      $display("FAIL R11 actual=%h expected=%h", pack_act(), 29'd0);
    end
    drive(0, 8'h00, 0, 8'd0,   8'd0,   0, 0, 0, 0, "R11 idle after reset");
    drive(1, 8'h00, 1, 8'd50,  8'd10,  0, 0, 1, 0, "R1 warn tx-side R4");
    drive(1, 8'h00, 1, 8'd60,  8'd10,  0, 0, 1, 0, "R3 repeat no event");
    drive(1, 8'h20, 1, 8'd10,  8'd130, 0, 0, 1, 0, "R2 rx passive R4");
    drive(1, 8'h00, 0, 8'd5,   8'd5,   0, 0, 1, 0, "R4 equal counters both sides");
    drive(1, 8'h40, 0, 8'd140, 8'd20,  0, 0, 1, 0, "R2 tx passive");
    drive(0, 8'h80, 1, 8'd255, 8'd0,   1, 1, 0, 0, "R10 strobe low ignored");
    drive(1, 8'hE0, 1, 8'd255, 8'd7,   0, 0, 1, 0, "R1 busoff priority R9");
    drive(1, 8'h98, 0, 8'd255, 8'd7,   1, 1, 1, 0, "R5 bit over form R9");
    drive(1, 8'h8D, 0, 8'd255, 8'd7,   1, 1, 1, 0, "R5 form over stuff crc");
    drive(1, 8'h87, 0, 8'd255, 8'd7,   1, 1, 1, 0, "R5 stuff over crc ack");
    drive(1, 8'h86, 0, 8'd255, 8'd7,   1, 1, 1, 0, "R5 crc over ack");
    drive(1, 8'h82, 0, 8'd255, 8'd7,   1, 1, 1, 0, "R5 ack alone");
    drive(1, 8'h90, 0, 8'd255, 8'd7,   1, 0, 1, 0, "R6 reporting off");
    drive(1, 8'h90, 0, 8'd255, 8'd7,   0, 1, 1, 0, "R6 irq off");
    drive(1, 8'hE0, 0, 8'd255, 8'd7,   1, 1, 1, 0, "R6 no protocol bit");
    drive(1, 8'h00, 0, 8'd0,   8'd0,   1, 1, 0, 1, "R8 restart over sample");
    drive(1, 8'h91, 0, 8'd30,  8'd90,  1, 1, 0, 0, "R7 busoff no auto-restart");
    drive(1, 8'h10, 1, 8'd30,  8'd90,  1, 1, 0, 0, "R7 silent while quit");
    drive(1, 8'h00, 0, 8'd0,   8'd0,   1, 1, 1, 0, "R7 still silent");
    drive(0, 8'h00, 0, 8'd0,   8'd0,   0, 0, 0, 1, "R8 restart clears quit");
    drive(1, 8'h11, 1, 8'd100, 8'd100, 1, 1, 0, 0, "R8 events resume");
    drive(0, 8'h00, 0, 8'd0,   8'd0,   0, 0, 0, 0, "R10 final idle");
    repeat (3) @(posedge clk);
    #5;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule